// File: doc/BRIEF.md
# Transaction Tag Remapper

This block sits between a requester that labels each request with a tag of its own choosing and a memory port that wants transaction IDs drawn from a fixed pool. Each request accepted downstream is given the lowest-numbered free ID. The requester's tag is written into a table slot selected by that ID. When a response comes back carrying a downstream ID, the block reads the stored tag for that ID and presents it upstream. On the response handshake the ID goes back into the pool.

Both directions use valid/ready handshakes. The request and response payloads pass through unchanged. While every ID is outstanding, the block stops accepting requests. The pool size must not exceed the number of responses the requester can absorb, or a deadlock becomes possible. A response whose ID is not outstanding is reported on a one-cycle error output and has no effect on the pool.

Top module: `tag_remap`

## Requirements
- R1: A synchronous active-high reset marks every ID free and clears `rsp_unknown_id`; the first request presented after reset is offered with `dn_req_id` = 0.
- R2: `dn_req_valid` = `up_req_valid` AND (some ID free); `up_req_ready` = `dn_req_ready` AND (some ID free).
- R3: The offered `dn_req_id` is always the lowest-numbered ID that is not outstanding.
- R4: An ID is consumed only in a cycle where `dn_req_valid` and `dn_req_ready` are both high; while `dn_req_ready` is low, the offered ID stays the same.
- R5: `dn_req_payload` equals `up_req_payload`, and `up_rsp_payload` equals `dn_rsp_payload`.
- R6: `up_rsp_valid` follows `dn_rsp_valid` and `dn_rsp_ready` follows `up_rsp_ready`. In the same cycle, `up_rsp_tag` shows the tag that was stored when the ID on `dn_rsp_id` was allocated.
- R7: A response handshake on an outstanding ID frees that ID. From the next cycle it can be allocated again.
- R8: When all 2^ID_W IDs are outstanding, `up_req_ready` and `dn_req_valid` are both low.
- R9: An allocation and a release in the same cycle both take effect.
- R10: A response handshake whose ID is not outstanding raises `rsp_unknown_id` for exactly the next cycle and leaves the pool unchanged.
- R11: No ID is offered downstream while it is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_req_valid | input | 1 | Upstream request valid |
| up_req_ready | output | 1 | Upstream request ready |
| up_req_tag | input | TAG_W | Requester's own tag |
| up_req_payload | input | PAY_W | Request payload (address, data, opcode) |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream request ready |
| dn_req_id | output | ID_W | Allocated transaction ID |
| dn_req_payload | output | PAY_W | Request payload, passed through |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Downstream response ready |
| dn_rsp_id | input | ID_W | ID carried by the response |
| dn_rsp_payload | input | PAY_W | Response payload |
| up_rsp_valid | output | 1 | Upstream response valid |
| up_rsp_ready | input | 1 | Upstream response ready |
| up_rsp_tag | output | TAG_W | Restored original tag |
| up_rsp_payload | output | PAY_W | Response payload, passed through |
| rsp_unknown_id | output | 1 | Pulse: the previous response's ID was not outstanding |

## Verification
The hardest situations to reach from the ports are a full pool, and a release that lands in the same cycle as a new allocation while older IDs are still outstanding. Together these show whether the lowest-free choice and the tag table stay consistent.

The directed vectors retire responses out of issue order. They hold a response stalled while its tag is visible, overlap a release with an allocation, and fill all sixteen IDs before freeing one in the middle.

A long random phase follows. It uses random backpressure on both sides and returns outstanding IDs in random order. It compares every offered ID and every restored tag against a model of the pool kept in the bench.

// File: rtl/tag_remap_pkg.sv
package tag_remap_pkg;
  localparam int unsigned DEF_ID_W  = 4;
  localparam int unsigned DEF_TAG_W = 8;
  localparam int unsigned DEF_PAY_W = 32;
endpackage

// File: rtl/tag_remap_pool.sv
module tag_remap_pool #(
  parameter int unsigned ID_W = tag_remap_pkg::DEF_ID_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            rel,
  input  logic [ID_W-1:0] rel_id,
  output logic            avail,
  output logic [ID_W-1:0] free_id,
  output logic            rel_hit
);
  localparam int unsigned NUM = 1 << ID_W;

  logic [NUM-1:0] in_use;

  // lowest-index-first search over the free slots
  always_comb begin
    free_id = '0;
    avail   = 1'b0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (!in_use[i]) begin
        free_id = ID_W'(i);
        avail   = 1'b1;
      end
    end
  end

  assign rel_hit = in_use[rel_id];

  // take and release never name the same slot: one is free, the other busy
  always_ff @(posedge clk) begin
    if (rst) begin
      in_use <= '0;
    end else begin
      if (take && avail)  in_use[free_id] <= 1'b1;
      if (rel && rel_hit) in_use[rel_id]  <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_remap_table.sv
module tag_remap_table #(
  parameter int unsigned ID_W  = tag_remap_pkg::DEF_ID_W,
  parameter int unsigned TAG_W = tag_remap_pkg::DEF_TAG_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ID_W-1:0]  waddr,
  input  logic [TAG_W-1:0] wdata,
  input  logic [ID_W-1:0]  raddr,
  output logic [TAG_W-1:0] rdata
);
  localparam int unsigned NUM = 1 << ID_W;

  logic [TAG_W-1:0] mem [NUM];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tag_remap.sv
module tag_remap #(
  parameter int unsigned ID_W  = tag_remap_pkg::DEF_ID_W,
  parameter int unsigned TAG_W = tag_remap_pkg::DEF_TAG_W,
  parameter int unsigned PAY_W = tag_remap_pkg::DEF_PAY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_req_valid,
  output logic             up_req_ready,
  input  logic [TAG_W-1:0] up_req_tag,
  input  logic [PAY_W-1:0] up_req_payload,
  output logic             dn_req_valid,
  input  logic             dn_req_ready,
  output logic [ID_W-1:0]  dn_req_id,
  output logic [PAY_W-1:0] dn_req_payload,
  input  logic             dn_rsp_valid,
  output logic             dn_rsp_ready,
  input  logic [ID_W-1:0]  dn_rsp_id,
  input  logic [PAY_W-1:0] dn_rsp_payload,
  output logic             up_rsp_valid,
  input  logic             up_rsp_ready,
  output logic [TAG_W-1:0] up_rsp_tag,
  output logic [PAY_W-1:0] up_rsp_payload,
  output logic             rsp_unknown_id
);
  logic            avail;
  logic [ID_W-1:0] free_id;
  logic            rel_hit;
  logic            req_fire;
  logic            rsp_fire;

  assign req_fire = up_req_valid && dn_req_ready && avail;
  assign rsp_fire = dn_rsp_valid && up_rsp_ready;

  tag_remap_pool #(.ID_W(ID_W)) u_pool (
    .clk     (clk),
    .rst     (rst),
    .take    (req_fire),
    .rel     (rsp_fire),
    .rel_id  (dn_rsp_id),
    .avail   (avail),
    .free_id (free_id),
    .rel_hit (rel_hit)
  );

  tag_remap_table #(.ID_W(ID_W), .TAG_W(TAG_W)) u_table (
    .clk   (clk),
    .we    (req_fire),
    .waddr (free_id),
    .wdata (up_req_tag),
    .raddr (dn_rsp_id),
    .rdata (up_rsp_tag)
  );

  assign dn_req_valid   = up_req_valid && avail;
  assign up_req_ready   = dn_req_ready && avail;
  assign dn_req_id      = free_id;
  assign dn_req_payload = up_req_payload;

  assign up_rsp_valid   = dn_rsp_valid;
  assign dn_rsp_ready   = up_rsp_ready;
  assign up_rsp_payload = dn_rsp_payload;

  always_ff @(posedge clk) begin
    if (rst) rsp_unknown_id <= 1'b0;
    else     rsp_unknown_id <= rsp_fire && !rel_hit;
  end
endmodule

// File: rtl/tag_remap_chk.sv
module tag_remap_chk #(
  parameter int unsigned ID_W  = tag_remap_pkg::DEF_ID_W,
  parameter int unsigned TAG_W = tag_remap_pkg::DEF_TAG_W,
  parameter int unsigned PAY_W = tag_remap_pkg::DEF_PAY_W
) (
  input logic             clk,
  input logic             rst,
  input logic             up_req_valid,
  input logic             up_req_ready,
  input logic [TAG_W-1:0] up_req_tag,
  input logic [PAY_W-1:0] up_req_payload,
  input logic             dn_req_valid,
  input logic             dn_req_ready,
  input logic [ID_W-1:0]  dn_req_id,
  input logic [PAY_W-1:0] dn_req_payload,
  input logic             dn_rsp_valid,
  input logic             dn_rsp_ready,
  input logic [ID_W-1:0]  dn_rsp_id,
  input logic [PAY_W-1:0] dn_rsp_payload,
  input logic             up_rsp_valid,
  input logic             up_rsp_ready,
  input logic [TAG_W-1:0] up_rsp_tag,
  input logic [PAY_W-1:0] up_rsp_payload,
  input logic             rsp_unknown_id
);
  localparam int unsigned NUM = 1 << ID_W;

  logic [NUM-1:0]   sh_busy;
  logic [TAG_W-1:0] sh_tag [NUM];
  logic             exp_flag;
  logic             dn_hs;
  logic             rsp_hs;

  assign dn_hs  = dn_req_valid && dn_req_ready;
  assign rsp_hs = dn_rsp_valid && dn_rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_busy  <= '0;
      exp_flag <= 1'b0;
    end else begin
      if (dn_hs) begin
        sh_busy[dn_req_id] <= 1'b1;
        sh_tag[dn_req_id]  <= up_req_tag;
      end
      if (rsp_hs && sh_busy[dn_rsp_id]) sh_busy[dn_rsp_id] <= 1'b0;
      exp_flag <= rsp_hs && !sh_busy[dn_rsp_id];
    end
  end

  a_r2_valid_needs_up: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> up_req_valid);
  a_r2_accept_needs_dn: assert property (@(posedge clk) disable iff (rst)
    up_req_ready |-> dn_req_ready);
  a_r2_gates_agree: assert property (@(posedge clk) disable iff (rst)
    (up_req_valid && dn_req_ready) |-> (up_req_ready == dn_req_valid));
  a_r8_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (&sh_busy) |-> (!up_req_ready && !dn_req_valid));
  a_r11_no_reuse: assert property (@(posedge clk) disable iff (rst)
    dn_req_valid |-> !sh_busy[dn_req_id]);
  a_r6_tag_restored: assert property (@(posedge clk) disable iff (rst)
    (dn_rsp_valid && sh_busy[dn_rsp_id]) |-> (up_rsp_tag == sh_tag[dn_rsp_id]));
  a_r10_unknown_flag: assert property (@(posedge clk) disable iff (rst)
    rsp_unknown_id == exp_flag);
endmodule

bind tag_remap tag_remap_chk #(.ID_W(ID_W), .TAG_W(TAG_W), .PAY_W(PAY_W)) u_chk (.*);

// File: tb/tb_tag_remap.sv
`timescale 1ns/1ps
module tb_tag_remap;
  localparam int unsigned ID_W  = 4;
  localparam int unsigned TAG_W = 8;
  localparam int unsigned PAY_W = 32;
  localparam int unsigned NUM   = 1 << ID_W;
  localparam int unsigned NVEC  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_req_valid = 1'b0, dn_req_ready = 1'b0, dn_rsp_valid = 1'b0, up_rsp_ready = 1'b0;
  logic [TAG_W-1:0] up_req_tag = '0;
  logic [PAY_W-1:0] up_req_payload = '0, dn_rsp_payload = '0;
  logic [ID_W-1:0]  dn_rsp_id = '0;
  logic up_req_ready, dn_req_valid, dn_rsp_ready, up_rsp_valid, rsp_unknown_id;
  logic [ID_W-1:0]  dn_req_id;
  logic [TAG_W-1:0] up_rsp_tag;
  logic [PAY_W-1:0] dn_req_payload, up_rsp_payload;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tag_remap #(.ID_W(ID_W), .TAG_W(TAG_W), .PAY_W(PAY_W)) dut (.*);

  // vector: uv dr tag[8] rv rid[4] rr | ur dv did[4] tchk etag[8]
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b1,1'b0,8'hA1,1'b0,4'd0,1'b0, 1'b0,1'b1,4'd0,1'b0,8'h00},
    {1'b1,1'b1,8'hA1,1'b0,4'd0,1'b0, 1'b1,1'b1,4'd0,1'b0,8'h00},
    {1'b1,1'b1,8'hB2,1'b0,4'd0,1'b0, 1'b1,1'b1,4'd1,1'b0,8'h00},
    {1'b1,1'b1,8'hC3,1'b0,4'd0,1'b0, 1'b1,1'b1,4'd2,1'b0,8'h00},
    {1'b0,1'b1,8'h00,1'b1,4'd1,1'b1, 1'b1,1'b0,4'd3,1'b1,8'hB2},
    {1'b1,1'b1,8'hD4,1'b1,4'd0,1'b1, 1'b1,1'b1,4'd1,1'b1,8'hA1},
    {1'b1,1'b1,8'hE5,1'b1,4'd1,1'b0, 1'b1,1'b1,4'd0,1'b1,8'hD4},
    {1'b0,1'b1,8'h00,1'b1,4'd1,1'b1, 1'b1,1'b0,4'd3,1'b1,8'hD4},
    {1'b1,1'b1,8'hF6,1'b1,4'd2,1'b1, 1'b1,1'b1,4'd1,1'b1,8'hC3}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic uv, input logic dr, input logic [TAG_W-1:0] tg,
                       input logic rv, input logic [ID_W-1:0] rid, input logic rr);
    up_req_valid = uv; dn_req_ready = dr; up_req_tag = tg;
    dn_rsp_valid = rv; dn_rsp_id = rid; up_rsp_ready = rr;
    #1;
  endtask

  task automatic do_reset();
    drive(0, 0, '0, 0, '0, 0);
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit busy [NUM];
    logic [TAG_W-1:0] tags [NUM];
    @(negedge clk);
    do_reset();

    // R1: state right after reset
    drive(1, 0, 8'h11, 0, '0, 0);
    chk(dn_req_id == 0, "R1 first id", 32'(dn_req_id), 0);
    chk(rsp_unknown_id == 0, "R1 flag clear", 32'(rsp_unknown_id), 0);

    // vector table: R2 R3 R4 R6 R7 R9
    for (int i = 0; i < int'(NVEC); i++) begin
      logic [30:0] v;
      v = VEC[i];
      drive(v[30], v[29], v[28:21], v[20], v[19:16], v[15]);
      chk(up_req_ready == v[14], "R2 up_req_ready", 32'(up_req_ready), 32'(v[14]));
      chk(dn_req_valid == v[13], "R2 dn_req_valid", 32'(dn_req_valid), 32'(v[13]));
      chk(dn_req_id == v[12:9], "R3 R9 dn_req_id", 32'(dn_req_id), 32'(v[12:9]));
      chk(up_rsp_valid == v[20], "R6 up_rsp_valid", 32'(up_rsp_valid), 32'(v[20]));
      chk(dn_rsp_ready == v[15], "R6 dn_rsp_ready", 32'(dn_rsp_ready), 32'(v[15]));
      if (v[8]) chk(up_rsp_tag == v[7:0], "R6 R7 up_rsp_tag", 32'(up_rsp_tag), 32'(v[7:0]));
      step();
    end

    // R1: reset frees outstanding IDs 0 and 1
    do_reset();
    drive(1, 0, 8'h22, 0, '0, 0);
    chk(dn_req_id == 0, "R1 id after reset", 32'(dn_req_id), 0);

    // R4: held without ready, the offer does not move
    for (int k = 0; k < 3; k++) begin
      step();
      drive(1, 0, 8'h22, 0, '0, 0);
      chk(dn_req_id == 0, "R4 id held", 32'(dn_req_id), 0);
      chk(up_req_ready == 0, "R4 not accepted", 32'(up_req_ready), 0);
    end

    // R5 payload pass-through, then fill the pool (R8)
    for (int k = 0; k < int'(NUM); k++) begin
      up_req_payload = 32'hC0DE_0000 + 32'(k);
      dn_rsp_payload = 32'h5EED_0000 + 32'(k);
      drive(1, 1, 8'(8'h40 + k), 0, '0, 0);
      chk(dn_req_payload == up_req_payload, "R5 req payload", dn_req_payload, up_req_payload);
      chk(up_rsp_payload == dn_rsp_payload, "R5 rsp payload", up_rsp_payload, dn_rsp_payload);
      chk(dn_req_id == ID_W'(k), "R3 fill order", 32'(dn_req_id), 32'(k));
      step();
    end
    drive(1, 1, 8'h99, 0, '0, 0);
    chk(up_req_ready == 0, "R8 full ready", 32'(up_req_ready), 0);
    chk(dn_req_valid == 0, "R8 full valid", 32'(dn_req_valid), 0);

    // R7: free ID 7; still full this cycle, ID 7 offered next cycle
    drive(1, 1, 8'h99, 1, 4'd7, 1);
    chk(up_rsp_tag == 8'h47, "R6 tag of id7", 32'(up_rsp_tag), 32'h47);
    chk(up_req_ready == 0, "R7 not yet free", 32'(up_req_ready), 0);
    step();
    drive(1, 0, 8'h99, 0, '0, 0);
    chk(dn_req_valid == 1, "R7 reusable", 32'(dn_req_valid), 1);
    chk(dn_req_id == 7, "R7 id 7 offered", 32'(dn_req_id), 7);

    // R10: response on a free ID
    do_reset();
    drive(1, 1, 8'h01, 0, '0, 0); step();
    drive(1, 1, 8'h02, 0, '0, 0); step();
    drive(0, 0, '0, 1, 4'd9, 1);
    step();
    drive(1, 0, 8'h03, 0, '0, 0);
    chk(rsp_unknown_id == 1, "R10 flag raised", 32'(rsp_unknown_id), 1);
    chk(dn_req_id == 2, "R10 pool unchanged", 32'(dn_req_id), 2);
    step();
    drive(1, 0, 8'h03, 0, '0, 0);
    chk(rsp_unknown_id == 0, "R10 flag one cycle", 32'(rsp_unknown_id), 0);
    drive(0, 0, '0, 1, 4'd1, 1);
    chk(up_rsp_tag == 8'h02, "R6 tag of id1", 32'(up_rsp_tag), 32'h02);
    step();
    drive(0, 0, '0, 0, '0, 0);
    chk(rsp_unknown_id == 0, "R10 known id no flag", 32'(rsp_unknown_id), 0);

    // random out-of-order traffic: R3 R6 R9 R11
    do_reset();
    for (int j = 0; j < int'(NUM); j++) busy[j] = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      logic uv, dr, rv, rr, any_free;
      logic [TAG_W-1:0] tg;
      logic [ID_W-1:0] rid, low;
      int start;
      uv = ($urandom % 4) != 0;
      dr = ($urandom % 3) != 0;
      tg = TAG_W'($urandom);
      rr = ($urandom % 4) != 0;
      rv = 1'b0; rid = '0;
      start = int'($urandom % NUM);
      if (($urandom % 2) == 0) begin
        for (int j = 0; j < int'(NUM); j++) begin
          int idx;
          idx = (start + j) % int'(NUM);
          if (!rv && busy[idx]) begin rv = 1'b1; rid = ID_W'(idx); end
        end
      end
      any_free = 1'b0; low = '0;
      for (int j = int'(NUM) - 1; j >= 0; j--) if (!busy[j]) begin any_free = 1'b1; low = ID_W'(j); end
      drive(uv, dr, tg, rv, rid, rr);
      chk(up_req_ready == (dr && any_free), "R2 rand ready", 32'(up_req_ready), 32'(dr && any_free));
      chk(dn_req_valid == (uv && any_free), "R2 rand valid", 32'(dn_req_valid), 32'(uv && any_free));
      if (dn_req_valid) begin
        chk(dn_req_id == low, "R3 rand lowest", 32'(dn_req_id), 32'(low));
        chk(!busy[dn_req_id], "R11 no reuse", 32'(dn_req_id), 32'(low));
      end
      if (rv) chk(up_rsp_tag == tags[rid], "R6 rand tag", 32'(up_rsp_tag), 32'(tags[rid]));
      if (uv && dr && any_free) begin busy[low] = 1'b1; tags[low] = tg; end
      if (rv && rr) busy[rid] = 1'b0;
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule